// File: doc/BRIEF.md
# SPI Control Register Access Engine

This block sits on the device side of a full-duplex serial link and carries out register reads and writes that a host requests over it. A word-level front end handles the bit shifting. It hands the engine one 32-bit word each time a word completes while chip select is low, and it shifts out whatever the engine holds on `txWord` during the following word slot. The first word of each chip-select-low transaction is a control header. The engine checks the header's parity, decodes it, and then drives a simple single-cycle register bus once for every register the header asks for.

The reply stream lags the host by one word, so the host can confirm what the device actually executed. The slot after the header carries the header echo. Each later slot carries either the data read from a register or an echo of the word just written. Once all requested registers have been accessed, any further words get zero replies and cause no access. A header flagged as data traffic, or a header with bad parity, causes no register access. Raising chip select ends the transaction at once, even if some accesses have not yet been made.

Top module: `spi_ctl_engine`

## Requirements
- R1: A first word with bit 31 set (data traffic) is rejected. It causes no register access, and every reply until chip select rises is 0x00000000.
- R2: Header parity is odd over all 32 bits, with bit 0 as the parity bit. If the check fails, no register is accessed, the echo equals the received header with bit 30 set, and every later reply in the transaction is zero.
- R3: After a good header, the next reply equals the header with bit 30 forced to 0, whatever value the host sent in that bit.
- R4: When header bit 28 is 0, the register address goes up by one after each access. When bit 28 is 1, every access uses the start address.
- R5: Header bits 7..1 hold the register count minus one. Exactly that many plus one accesses take place, one per word after the header. Words beyond that get zero replies and cause no access.
- R6: When header bit 29 is 1 (write), each data word is written to the current register, and the reply in the next slot is an echo of that word.
- R7: When header bit 29 is 0 (read), each word after the header starts a read. The reply in the next slot is the read data, and the host's word has no effect.
- R8: A read that the register bus does not acknowledge returns 0x00000000.
- R9: While chip select is high, the reply is zero and no access takes place. Raising chip select mid-transaction drops the remaining accesses, and the next low period begins with a fresh header.
- R10: Header bits 27..24 drive the map select output, and bits 23..8 give the first register address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low, level from the front end |
| rxValid | input | 1 | One-cycle strobe: a host word has completed |
| rxWord | input | 32 | Host word delivered with rxValid |
| txWord | output | 32 | Word to shift out in the next slot |
| regReq | output | 1 | Register access strobe, one cycle |
| regWrite | output | 1 | Access is a write when 1 |
| regMms | output | 4 | Selected memory map |
| regAddr | output | 16 | Register address |
| regWdata | output | 32 | Write data |
| regRdata | input | 32 | Read data, valid in the same cycle as regReq |
| regAck | input | 1 | Register exists, valid in the same cycle as regReq |

## Verification
The assertions assume that rxValid is a single-cycle pulse that arrives only while csN is low. They also assume that regRdata and regAck settle combinationally in the same cycle as regReq. The bench follows these rules: it raises rxValid for exactly one cycle per word, always inside a low chip-select window. Its register model answers from a 16-entry array, acknowledges only addresses below 16, and so exercises both the acknowledged and the unacknowledged read paths.

// File: rtl/spictl_pkg.sv
package spictl_pkg;
  localparam int WORD_W   = 32;
  localparam int MMS_W    = 4;
  localparam int ADDR_W   = 16;
  localparam int LEN_W    = 7;
  localparam int CNT_W    = LEN_W + 1;
  // header field positions (decoded by the host side too)
  localparam int BIT_DNC  = 31;
  localparam int BIT_BAD  = 30;
  localparam int BIT_WNR  = 29;
  localparam int BIT_NINC = 28;
  localparam int MMS_LSB  = 24;
  localparam int ADDR_LSB = 8;
  localparam int LEN_LSB  = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} ctlState_t;

  typedef struct packed {
    logic clear;
    logic hdrGood;
    logic hdrBad;
    logic access;
    logic zeroOut;
  } ctlStrobe_t;
endpackage

// File: rtl/spi_ctl_fsm.sv
module spi_ctl_fsm
  import spictl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rxValid,
  input  logic [WORD_W-1:0] rxWord,
  output ctlStrobe_t        strobe
);
  ctlState_t        state;
  logic [CNT_W-1:0] remain;
  logic             parityOk;
  logic             isData;
  logic [LEN_W-1:0] lenField;

  assign parityOk = ^rxWord;
  assign isData   = rxWord[BIT_DNC];
  assign lenField = rxWord[LEN_LSB +: LEN_W];

  always_comb begin
    strobe = '0;
    if (csN) begin
      strobe.clear = 1'b1;
    end else if (rxValid) begin
      unique case (state)
        ST_IDLE: begin
          if (isData)        strobe.zeroOut = 1'b1;
          else if (parityOk) strobe.hdrGood = 1'b1;
          else               strobe.hdrBad  = 1'b1;
        end
        ST_RUN: begin
          if (remain != '0) strobe.access  = 1'b1;
          else              strobe.zeroOut = 1'b1;
        end
        default: strobe.zeroOut = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else if (strobe.clear) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else if (strobe.hdrGood) begin
      state  <= ST_RUN;
      remain <= CNT_W'(lenField) + CNT_W'(1);
    end else if (strobe.hdrBad || (strobe.zeroOut && state == ST_IDLE)) begin
      state  <= ST_DRAIN;
    end else if (strobe.access) begin
      remain <= remain - CNT_W'(1);
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R1
  AST_DATA_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !csN && rxValid && rxWord[BIT_DNC]) |=> state == ST_DRAIN); // R1
  AST_BAD_NO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !csN && rxValid && !(^rxWord)) |=> state != ST_RUN); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.access |=> remain == $past(remain) - CNT_W'(1)); // R5
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (state == ST_IDLE && remain == '0)); // R9
endmodule

// File: rtl/spi_ctl_datapath.sv
module spi_ctl_datapath
  import spictl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [WORD_W-1:0] rxWord,
  input  logic [WORD_W-1:0] regRdata,
  input  logic              regAck,
  output logic [WORD_W-1:0] txWord,
  output logic              regReq,
  output logic              regWrite,
  output logic [MMS_W-1:0]  regMms,
  output logic [ADDR_W-1:0] regAddr,
  output logic [WORD_W-1:0] regWdata
);
  logic              wrMode;
  logic              noInc;
  logic [MMS_W-1:0]  mmsReg;
  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] txReg;
  logic [WORD_W-1:0] badMask;

  assign badMask  = WORD_W'(1) << BIT_BAD;
  assign regReq   = strobe.access;
  assign regWrite = wrMode;
  assign regMms   = mmsReg;
  assign regAddr  = addrReg;
  assign regWdata = rxWord;
  assign txWord   = txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrMode  <= 1'b0;
      noInc   <= 1'b0;
      mmsReg  <= '0;
      addrReg <= '0;
    end else if (strobe.hdrGood) begin
      wrMode  <= rxWord[BIT_WNR];
      noInc   <= rxWord[BIT_NINC];
      mmsReg  <= rxWord[MMS_LSB +: MMS_W];
      addrReg <= rxWord[ADDR_LSB +: ADDR_W];
    end else if (strobe.access && !noInc) begin
      addrReg <= addrReg + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 txReg <= '0;
    else if (strobe.clear)     txReg <= '0;
    else if (strobe.hdrGood)   txReg <= rxWord & ~badMask;
    else if (strobe.hdrBad)    txReg <= rxWord | badMask;
    else if (strobe.access)    txReg <= wrMode ? rxWord : (regAck ? regRdata : '0);
    else if (strobe.zeroOut)   txReg <= '0;
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.access && !noInc) |=> regAddr == $past(regAddr) + ADDR_W'(1)); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.access && noInc) |=> $stable(regAddr)); // R4
  AST_BAD_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hdrBad |=> txWord[BIT_BAD]); // R2
  AST_ECHO_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hdrGood |=> !txWord[BIT_BAD]); // R3
  AST_WR_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.access && wrMode) |=> txWord == $past(rxWord)); // R6
  AST_UNACK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.access && !wrMode && !regAck) |=> txWord == '0); // R8
endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine
  import spictl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rxValid,
  input  logic [WORD_W-1:0] rxWord,
  output logic [WORD_W-1:0] txWord,
  output logic              regReq,
  output logic              regWrite,
  output logic [MMS_W-1:0]  regMms,
  output logic [ADDR_W-1:0] regAddr,
  output logic [WORD_W-1:0] regWdata,
  input  logic [WORD_W-1:0] regRdata,
  input  logic              regAck
);
  ctlStrobe_t strobe;

  spi_ctl_fsm u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .rxValid (rxValid),
    .rxWord  (rxWord),
    .strobe  (strobe)
  );

  spi_ctl_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rxWord   (rxWord),
    .regRdata (regRdata),
    .regAck   (regAck),
    .txWord   (txWord),
    .regReq   (regReq),
    .regWrite (regWrite),
    .regMms   (regMms),
    .regAddr  (regAddr),
    .regWdata (regWdata)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !regReq); // R9
endmodule

// File: tb/spi_ctl_engine_bench.sv
module spi_ctl_engine_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        csN;
  logic        rxValid;
  logic [31:0] rxWord;
  logic [31:0] txWord;
  logic        regReq, regWrite, regAck;
  logic [3:0]  regMms;
  logic [15:0] regAddr;
  logic [31:0] regWdata, regRdata;

  always #2 clk = ~clk;

  spi_ctl_engine u_spi_ctl_engine (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxWord(rxWord),
    .txWord(txWord), .regReq(regReq), .regWrite(regWrite), .regMms(regMms),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .regAck(regAck)
  );

  // register model: 16 registers at addresses 0..15, others unacknowledged
  logic [31:0] mem [16];
  logic [31:0] expMem [16];
  int          accCnt;
  logic [15:0] addrLog [64];
  logic [3:0]  mmsLog [64];

  assign regAck   = (regAddr < 16'd16);
  assign regRdata = mem[regAddr[3:0]];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 16; k++) mem[k] <= 32'h1000_0000 + k;
      accCnt <= 0;
    end else if (regReq) begin
      addrLog[accCnt % 64] <= regAddr;
      mmsLog[accCnt % 64]  <= regMms;
      accCnt <= accCnt + 1;
      if (regWrite && regAck) mem[regAddr[3:0]] <= regWdata;
    end
  end

  int nChk = 0;
  int nFail = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w, output logic [31:0] rep);
    @(negedge clk);
    rxValid = 1'b1;
    rxWord  = w;
    @(posedge clk);
    #1;
    rep = txWord;
    rxValid = 1'b0;
  endtask

  task automatic csLow();
    @(negedge clk);
    csN = 1'b0;
  endtask

  task automatic csHigh();
    @(negedge clk);
    csN = 1'b1;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] mkHdr(input logic wr, input logic aid, input logic [3:0] mms,
                                        input logic [15:0] addr, input logic [6:0] len);
    logic [31:0] h;
    h = {1'b0, 1'b0, wr, aid, mms, addr, len, 1'b0};
    h[0] = ~^h[31:1];
    return h;
  endfunction

  typedef struct packed {
    logic        wr;
    logic        aid;
    logic [3:0]  mms;
    logic [15:0] addr;
    logic [6:0]  len;
    logic [7:0]  expAcc;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 4'd1, 16'd2,      7'd3, 8'd4},
    '{1'b0, 1'b0, 4'd1, 16'd2,      7'd3, 8'd4},
    '{1'b0, 1'b1, 4'd2, 16'd5,      7'd2, 8'd3},
    '{1'b1, 1'b1, 4'd3, 16'd9,      7'd1, 8'd2},
    '{1'b0, 1'b0, 4'd4, 16'd9,      7'd0, 8'd1},
    '{1'b0, 1'b0, 4'd5, 16'd14,     7'd3, 8'd4},
    '{1'b1, 1'b0, 4'd6, 16'hFFFF,   7'd0, 8'd1}
  };

  task automatic runVec(input vec_t v);
    logic [31:0] hdr, rep, d, ex;
    logic [15:0] a;
    int          n, start;
    hdr = mkHdr(v.wr, v.aid, v.mms, v.addr, v.len);
    n = int'(v.len) + 1;
    start = accCnt;
    csLow();
    sendWord(hdr, rep);
    chk(rep == hdr, "R3 header echo", rep, hdr);
    for (int i = 0; i < n; i++) begin
      a = v.addr + (v.aid ? 16'd0 : 16'(i));
      if (v.wr) begin
        d = 32'hC0DE_0000 ^ (32'(i) * 32'h111) ^ {16'h0, v.addr};
        sendWord(d, rep);
        if (a < 16) expMem[a[3:0]] = d;
        chk(rep == d, "R6 write echo", rep, d);
      end else begin
        d = 32'hDEAD_0000 + 32'(i);
        sendWord(d, rep);
        ex = (a < 16) ? expMem[a[3:0]] : 32'h0;
        chk(rep == ex, (a < 16) ? "R7 read data (R4 address)" : "R8 unacked read", rep, ex);
      end
    end
    sendWord(32'hFFFF_FFFF, rep);
    chk(rep == 32'h0, "R5 reply after last access", rep, 32'h0);
    csHigh();
    chk((accCnt - start) == int'(v.expAcc), "R5 access count", 32'(accCnt - start), 32'(v.expAcc));
    chk(addrLog[start % 64] == v.addr, "R10 first address", 32'(addrLog[start % 64]), 32'(v.addr));
    chk(mmsLog[start % 64] == v.mms, "R10 map select", 32'(mmsLog[start % 64]), 32'(v.mms));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] h, rep;
    int          start;
    rstN = 1'b0; csN = 1'b1; rxValid = 1'b0; rxWord = '0;
    for (int k = 0; k < 16; k++) expMem[k] = 32'h1000_0000 + k;
    repeat (3) @(posedge clk);
    #1;
    chk(txWord == 32'h0, "R9 reset reply", txWord, 32'h0);
    chk(regReq == 1'b0, "R9 reset no access", 32'(regReq), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NVEC; v++) runVec(VECS[v]);

    // R2: bad parity header
    start = accCnt;
    h = mkHdr(1'b1, 1'b0, 4'd1, 16'd3, 7'd2) ^ 32'h1;
    csLow();
    sendWord(h, rep);
    chk(rep == (h | 32'h4000_0000), "R2 bad header echo", rep, h | 32'h4000_0000);
    for (int i = 0; i < 3; i++) begin
      sendWord(32'h5555_0000 + 32'(i), rep);
      chk(rep == 32'h0, "R2 zero after bad header", rep, 32'h0);
    end
    csHigh();
    chk(accCnt == start, "R2 no access", 32'(accCnt - start), 32'h0);

    // R1: data header rejected
    start = accCnt;
    h = 32'h8020_0000 | mkHdr(1'b1, 1'b0, 4'd1, 16'd3, 7'd1);
    csLow();
    sendWord(h, rep);
    chk(rep == 32'h0, "R1 data header reply", rep, 32'h0);
    for (int i = 0; i < 2; i++) begin
      sendWord(32'hAAAA_0000 + 32'(i), rep);
      chk(rep == 32'h0, "R1 zero after data header", rep, 32'h0);
    end
    csHigh();
    chk(accCnt == start, "R1 no access", 32'(accCnt - start), 32'h0);

    // R3: host sets bit 30, echo clears it
    h = mkHdr(1'b0, 1'b0, 4'd1, 16'd4, 7'd0);
    h[30] = 1'b1;
    h[0] = ~^h[31:1];
    csLow();
    sendWord(h, rep);
    chk(rep == (h & ~32'h4000_0000), "R3 bit30 cleared in echo", rep, h & ~32'h4000_0000);
    sendWord(32'h0, rep);
    chk(rep == expMem[4], "R7 read after bit30 header", rep, expMem[4]);
    csHigh();

    // R9: abort mid-write
    start = accCnt;
    csLow();
    sendWord(mkHdr(1'b1, 1'b0, 4'd1, 16'd6, 7'd4), rep);
    sendWord(32'hBEEF_0006, rep);
    sendWord(32'hBEEF_0007, rep);
    expMem[6] = 32'hBEEF_0006;
    expMem[7] = 32'hBEEF_0007;
    csHigh();
    chk(txWord == 32'h0, "R9 reply zero after abort", txWord, 32'h0);
    chk((accCnt - start) == 2, "R9 accesses dropped", 32'(accCnt - start), 32'd2);
    runVec('{1'b0, 1'b0, 4'd1, 16'd6, 7'd2, 8'd3});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule